// File: doc/BRIEF.md
# Commutation-Synchronised Phase Output Register

This block is the control register for a six-switch motor bridge. One byte holds a two-bit field that picks the comparator input and six bits that enable the bridge switches. A bus write never changes the bridge directly. It lands in a shadow copy, and the shadow moves into the active copy when the commutation logic pulses `commit_event`. If `direct_mode` is high, the move happens on the same clock edge as the write. A bus read always returns the shadow copy.

The active selection field drives a one-hot select for a three-way analog comparator mux. Its fourth code switches to encoder mode. In that mode the mux select is all zero, `encoder_enable` is raised, and the two digital phase inputs pass to the encoder outputs. The active enable bits gate a shared PWM signal onto six switch outputs. A PWM-override input makes each output follow its enable bit, whatever the PWM level.

A two-state machine tracks whether the shadow and active copies agree. **SYNCED** is the reset state. **PENDING** means a buffered write is waiting for a transfer. The transition *buffer_write* (SYNCED→PENDING) fires on a write while neither `commit_event` nor `direct_mode` is high. The transition *transfer* (PENDING→SYNCED) fires on any cycle with `commit_event` or `direct_mode` high. In every other case the state holds: *hold_synced* in SYNCED, *hold_pending* in PENDING.

Top module: `phase_out_ctrl`

## Requirements
- R1: After reset, `rd_data` is 0x00, `pending` is 0, `gate_out` is 0, `encoder_enable` is 0, and `input_sel` is 3'b001.
- R2: On the cycle after a write, `rd_data` equals the full written byte.
- R3: A write with `commit_event`=0 and `direct_mode`=0 leaves the active copy unchanged and sets `pending` on the next cycle.
- R4: A `commit_event` copies the shadow into the active copy and clears `pending` on the next cycle.
- R5: When a write and a `commit_event` occur in the same cycle, the newly written value becomes active after that edge, and `pending` stays 0.
- R6: With `direct_mode`=1, a written value becomes active after the write edge, and `pending` stays 0.
- R7: Active bits [7:6] of 00, 01 and 10 drive `input_sel` to 3'b001, 3'b010 and 3'b100, with `encoder_enable`=0. Channel A is on bit 0, B on bit 1 and C on bit 2.
- R8: Active bits [7:6]=11 drives `input_sel` to 3'b000 and `encoder_enable` to 1. In that case `enc_a`/`enc_b` follow `phase_a_dig`/`phase_b_dig`. In every other case both encoder outputs are 0.
- R9: With `pwm_override`=0, `gate_out[i]` equals `pwm_in` AND active bit i, for i in 0..5.
- R10: With `pwm_override`=1, `gate_out[i]` equals active bit i, and `pwm_in` has no effect.
- R11: Each write replaces all eight shadow bits. Bits written as 0 read back as 0, whatever the earlier value.
- R12: A `commit_event` with no write pending leaves the active copy and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Byte to write into the shadow copy |
| rd_data | output | 8 | Shadow copy contents |
| direct_mode | input | 1 | Transfer shadow to active every cycle |
| commit_event | input | 1 | Single-cycle commutation pulse |
| pwm_in | input | 1 | Shared PWM signal |
| pwm_override | input | 1 | Outputs follow enable bits, ignoring PWM |
| phase_a_dig | input | 1 | Digital phase A input for the encoder path |
| phase_b_dig | input | 1 | Digital phase B input for the encoder path |
| input_sel | output | 3 | One-hot analog mux select (A, B, C) |
| encoder_enable | output | 1 | Encoder mode active |
| enc_a | output | 1 | Encoder channel A |
| enc_b | output | 1 | Encoder channel B |
| gate_out | output | 6 | Switch gate drives |
| pending | output | 1 | Buffered write waiting for transfer |

## Verification
Directed sequences come first. The first checks the reset state. The second writes 0xFF and then 0x40, which separates a full-byte replace from a merge. The third sends a commit with nothing pending, which must change nothing. A long seeded random run then mixes writes, commits, direct mode, override, PWM and phase inputs. Same-cycle write-plus-commit and direct writes occur often, and each is told apart from a buffered write by `pending` and by when the active outputs move. All four selection codes are reached, so the one-hot mux patterns can be compared against the encoder bypass.

// File: rtl/phase_out_pkg.sv
package phase_out_pkg;
    localparam int NUM_CH   = 6;
    localparam int SEL_W    = 2;
    localparam int REG_W    = NUM_CH + SEL_W;
    localparam int NUM_AIN  = 3;

    typedef enum logic {
        ST_SYNCED  = 1'b0,
        ST_PENDING = 1'b1
    } sync_state_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_A   = 2'b00,
        SEL_B   = 2'b01,
        SEL_C   = 2'b10,
        SEL_ENC = 2'b11
    } in_sel_t;
endpackage

// File: rtl/preload_stage.sv
module preload_stage
    import phase_out_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         direct_mode,
    input  logic         commit_event,
    output logic [W-1:0] shadow_q,
    output logic [W-1:0] active_q,
    output logic         pending
);
    sync_state_t state_q, state_d;
    logic [W-1:0] shadow_d;
    logic         xfer;

    assign xfer     = commit_event | direct_mode;
    assign shadow_d = wr_en ? wr_data : shadow_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SYNCED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNCED: begin
                if (wr_en && !xfer) begin
                    state_d = ST_PENDING;   // buffer_write
                end
            end
            ST_PENDING: begin
                if (xfer) begin
                    state_d = ST_SYNCED;    // transfer
                end
            end
            default: state_d = ST_SYNCED;
        endcase
    end

    // Data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            shadow_q <= shadow_d;
            if (xfer) begin
                active_q <= shadow_d;
            end
        end
    end

    // Outputs
    always_comb begin
        pending = (state_q == ST_PENDING);
    end

    a_r3_buffered_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !commit_event && !direct_mode) |=> pending);
    a_r3_buffered_holds_active: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_event && !direct_mode) |=> $stable(active_q));
    a_r4_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        commit_event |=> !pending);
    a_r5_write_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && commit_event) |=> (active_q == $past(wr_data)));
    a_r6_direct_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && direct_mode) |=> (active_q == $past(wr_data) && !pending));
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (shadow_q == $past(wr_data)));
endmodule

// File: rtl/input_router.sv
module input_router
    import phase_out_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel_code,
    input  logic               phase_a_dig,
    input  logic               phase_b_dig,
    output logic [NUM_AIN-1:0] input_sel,
    output logic               encoder_enable,
    output logic               enc_a,
    output logic               enc_b
);
    in_sel_t code;
    assign code = in_sel_t'(sel_code);

    always_comb begin
        input_sel      = '0;
        encoder_enable = 1'b0;
        unique case (code)
            SEL_A:   input_sel = NUM_AIN'(1) << 0;
            SEL_B:   input_sel = NUM_AIN'(1) << 1;
            SEL_C:   input_sel = NUM_AIN'(1) << 2;
            SEL_ENC: encoder_enable = 1'b1;
            default: input_sel = '0;
        endcase
    end

    assign enc_a = encoder_enable & phase_a_dig;
    assign enc_b = encoder_enable & phase_b_dig;

    a_r7_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(input_sel) && ((input_sel == '0) == encoder_enable));
    a_r8_enc_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        encoder_enable |-> (enc_a == phase_a_dig && enc_b == phase_b_dig));
    a_r8_enc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !encoder_enable |-> (!enc_a && !enc_b));
endmodule

// File: rtl/gate_driver.sv
module gate_driver
    import phase_out_pkg::*;
#(
    parameter int N = NUM_CH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] enable,
    input  logic         pwm_in,
    input  logic         pwm_override,
    output logic [N-1:0] gate_out
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        always_comb begin
            gate_out[i] = pwm_override ? enable[i] : (enable[i] & pwm_in);
        end
    end

    a_r10_override_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_override |-> (gate_out == enable));
    a_r9_off_channels_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_out & ~enable) == '0);
    a_r9_pwm_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_override && !pwm_in) |-> (gate_out == '0));
endmodule

// File: rtl/phase_out_ctrl.sv
module phase_out_ctrl
    import phase_out_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    input  logic                direct_mode,
    input  logic                commit_event,
    input  logic                pwm_in,
    input  logic                pwm_override,
    input  logic                phase_a_dig,
    input  logic                phase_b_dig,
    output logic [NUM_AIN-1:0]  input_sel,
    output logic                encoder_enable,
    output logic                enc_a,
    output logic                enc_b,
    output logic [NUM_CH-1:0]   gate_out,
    output logic                pending
);
    logic [REG_W-1:0] active_q;

    preload_stage #(.W(REG_W)) u_preload (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .direct_mode  (direct_mode),
        .commit_event (commit_event),
        .shadow_q     (rd_data),
        .active_q     (active_q),
        .pending      (pending)
    );

    input_router u_router (
        .clk            (clk),
        .rst_n          (rst_n),
        .sel_code       (active_q[REG_W-1 -: SEL_W]),
        .phase_a_dig    (phase_a_dig),
        .phase_b_dig    (phase_b_dig),
        .input_sel      (input_sel),
        .encoder_enable (encoder_enable),
        .enc_a          (enc_a),
        .enc_b          (enc_b)
    );

    gate_driver #(.N(NUM_CH)) u_gates (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (active_q[NUM_CH-1:0]),
        .pwm_in       (pwm_in),
        .pwm_override (pwm_override),
        .gate_out     (gate_out)
    );

    a_r12_idle_commit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_event && !wr_en && !pending && !direct_mode) |=> ($stable(input_sel) && $stable(encoder_enable)));
endmodule

// File: tb/phase_out_ctrl_tb.sv
module phase_out_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       direct_mode = 0, commit_event = 0, pwm_in = 0, pwm_override = 0;
    logic       phase_a_dig = 0, phase_b_dig = 0;
    logic [2:0] input_sel;
    logic       encoder_enable, enc_a, enc_b, pending;
    logic [5:0] gate_out;

    int checks = 0, errors = 0;
    logic [7:0] m_sh = 0, m_act = 0;
    logic       m_pend = 0;
    string      pend_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_out_ctrl dut_i (.*);

    function automatic logic [2:0] exp_sel(logic [7:0] a);
        case (a[7:6])
            2'b00: return 3'b001;
            2'b01: return 3'b010;
            2'b10: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [5:0] exp_gate(logic [7:0] a, logic pwm, logic ovr);
        return ovr ? a[5:0] : (a[5:0] & {6{pwm}});
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // model the posedge that just consumed the held inputs
    task automatic model_step();
        logic [7:0] nsh;
        logic       xf;
        nsh = wr_en ? wr_data : m_sh;
        xf  = commit_event | direct_mode;
        if (xf) m_act = nsh;
        if (xf) m_pend = 0; else if (wr_en) m_pend = 1;
        if (wr_en && direct_mode) pend_tag = "R6";
        else if (wr_en && commit_event) pend_tag = "R5";
        else if (xf) pend_tag = "R4";
        else pend_tag = "R3";
        m_sh = nsh;
    endtask

    task automatic check_all();
        logic enc;
        enc = (m_act[7:6] == 2'b11);
        chk("R2", "rd_data", rd_data, m_sh);
        chk(pend_tag, "pending", pending, m_pend);
        chk(enc ? "R8" : "R7", "input_sel", input_sel, exp_sel(m_act));
        chk(enc ? "R8" : "R7", "encoder_enable", encoder_enable, enc);
        chk("R8", "enc_a/b", {enc_a, enc_b}, {enc & phase_a_dig, enc & phase_b_dig});
        chk(pwm_override ? "R10" : "R9", "gate_out", gate_out, exp_gate(m_act, pwm_in, pwm_override));
    endtask

    task automatic cycle(logic w, logic [7:0] d, logic c, logic dm);
        wr_en = w; wr_data = d; commit_event = c; direct_mode = dm;
        @(negedge clk);
        model_step();
        check_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rd_data", rd_data, 0);
        chk("R1", "pending", pending, 0);
        chk("R1", "gate_out", gate_out, 0);
        chk("R1", "encoder_enable", encoder_enable, 0);
        chk("R1", "input_sel", input_sel, 3'b001);

        // R11 full-byte replace
        cycle(1, 8'hFF, 0, 1);
        cycle(1, 8'h40, 0, 0);
        chk("R11", "rd_data", rd_data, 8'h40);
        chk("R3", "active gates held", gate_out, exp_gate(8'hFF, pwm_in, pwm_override));
        cycle(0, 0, 1, 0);
        chk("R11", "input_sel", input_sel, 3'b010);
        // R12 idle commit
        cycle(0, 0, 1, 0);
        chk("R12", "input_sel", input_sel, 3'b010);
        chk("R12", "pending", pending, 0);
        // R8 encoder with phase inputs
        phase_a_dig = 1; phase_b_dig = 0;
        cycle(1, 8'hC5, 1, 0);
        chk("R8", "enc_a", enc_a, 1);
        chk("R8", "enc_b", enc_b, 0);
        // R10 override with pwm low
        pwm_in = 0; pwm_override = 1;
        cycle(0, 0, 0, 0);
        chk("R10", "gate_out", gate_out, 6'h05);

        for (int i = 0; i < 3000; i++) begin
            pwm_in       = 1'($urandom);
            pwm_override = ($urandom % 4) == 0;
            phase_a_dig  = 1'($urandom);
            phase_b_dig  = 1'($urandom);
            cycle(($urandom % 10) < 4, 8'($urandom), ($urandom % 5) == 0, ($urandom % 7) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule